// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Input

This block gathers one non-maskable interrupt line and eight external interrupt pins and offers the CPU a single request at a time: the most urgent one that the CPU can currently take. Each external pin has a programmable priority level from 0 to 15, a choice of edge or level sensing, and a polarity. The non-maskable line always carries level 16, is edge-detected and outranks every pin. All pins first pass through a two-flop synchronizer.

The CPU reports its block bit, its current mask level and whether it is asleep. It takes the presented request by raising `ack` while `req_valid` is high. One cycle later the block reports the accepted source and level, together with the mask level the CPU should adopt. Software sets the block up through a small write-only register port with four registers. CONTROL (address 0) holds bit 0, NMI edge (1 = rising, 0 = falling); bit 1, NMI override; bit 2, drop-on-withdraw; and bit 3, auto-mask. SENSE (address 1) holds bits 7:0, edge mode per pin (1 = edge, 0 = level), and bits 15:8, polarity per pin (1 = active high / rising, 0 = active low / falling). MASK (address 2) holds bits 7:0, a per-pin mask (1 = masked). PRIORITY (address 3) holds the 4-bit level of pin n in bits 4n+3:4n.

Top module: `pic_core`

## Requirements
- R1: `req_level` reports the programmed level of the presented pin. A pin programmed to level 0 is never presented.
- R2: The non-maskable line is presented as source code 8 with level 16. It wins over any pin, and CONTROL bit 0 selects which edge of it is detected.
- R3: The non-maskable line ignores edges that reach detection in the cycle of any CONTROL write and in the six cycles after it.
- R4: While `cpu_block` is 1, the non-maskable request is presented only if `cpu_sleep` is 1 or the override bit (CONTROL bit 1) is 1. No pin request is presented while `cpu_block` is 1.
- R5: Accepting the non-maskable request reports `acc_imask` equal to `cpu_imask` as it was at acceptance, even when auto-mask is on.
- R6: A pin in edge mode latches the active edge chosen by its polarity bit. The latch stays set after the pin returns and is cleared when that pin is accepted. A pin in level mode requests while its active level persists.
- R7: With drop-on-withdraw at 0, a level request whose pin goes inactive before acceptance stays presented until any interrupt is accepted. With drop-on-withdraw at 1, the request disappears when the pin goes inactive.
- R8: A masked pin is never presented. Setting its mask bit discards any held level request or latched edge, so the request does not come back when the pin is unmasked.
- R9: When auto-mask (CONTROL bit 3) is 1, accepting a pin reports `acc_imask` equal to the accepted level. When it is 0, `acc_imask` equals `cpu_imask` at acceptance. `acc_valid`, `acc_src` and `acc_level` appear in the cycle after `ack`.
- R10: A pin is presented only when its level is strictly above `cpu_imask`.
- R11: Among pins of equal highest level, the lowest-numbered pin is presented.
- R12: A change on a level-mode pin reaches `req_valid` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Raw non-maskable interrupt line |
| irq_pin | input | 8 | Raw external interrupt pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cpu_block | input | 1 | CPU block bit |
| cpu_sleep | input | 1 | CPU is in sleep or standby |
| cpu_imask | input | 5 | CPU current mask level |
| req_valid | output | 1 | A request is presented |
| req_src | output | 4 | Presented source (0-7 pins, 8 non-maskable) |
| req_level | output | 5 | Level of the presented source |
| ack | input | 1 | CPU accepts the presented request |
| acc_valid | output | 1 | One-cycle acceptance report |
| acc_src | output | 4 | Accepted source |
| acc_level | output | 5 | Accepted level |
| acc_imask | output | 5 | Mask level for the CPU to adopt |

## Verification
The checker watches every cycle for the invariants of the presented request. A request never carries level 0 or a masked pin. A pin request always sits above the CPU mask level and never appears while the CPU is blocked unless sleep or the override admits the non-maskable line. Acceptance reports follow an `ack` by exactly one cycle, with the correct mask level for both auto-mask and the non-maskable line. Some behaviours only the bench scenarios can show. These include the two-edge synchronizer latency, the blanking window after a control write, hold-on-withdraw against drop-on-withdraw, masks that discard held or latched requests, edge polarity, and tie-breaking by pin index under random priorities, masks and mask levels.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [1:0] {
    REG_CONTROL  = 2'd0,
    REG_SENSE    = 2'd1,
    REG_MASK     = 2'd2,
    REG_PRIORITY = 2'd3
  } pic_reg_e;

  localparam int CTL_NMI_RISE = 0;
  localparam int CTL_NMI_OVR  = 1;
  localparam int CTL_DROP     = 2;
  localparam int CTL_AUTO     = 3;
  localparam int CTL_W        = 4;
endpackage

// File: rtl/pic_sync2.sv
`timescale 1ns/1ps
module pic_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pic_src.sv
`timescale 1ns/1ps
module pic_src #(
  parameter int PRI_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s,
  input  logic             edge_mode,
  input  logic             pol_high,
  input  logic             masked,
  input  logic [PRI_W-1:0] lvl,
  input  logic             drop,
  input  logic             take_me,
  input  logic             take_any,
  output logic             req
);
  logic prev_q, prev_d;
  logic edge_q, edge_d;
  logic held_q, held_d;
  logic active, prev_active, edge_evt, live;

  assign active      = pol_high ? pin_s  : ~pin_s;
  assign prev_active = pol_high ? prev_q : ~prev_q;
  assign edge_evt    = active & ~prev_active;
  assign live        = ~masked & (lvl != '0);

  always_comb begin
    prev_d = pin_s;
    edge_d = edge_q;
    if (!edge_mode || masked)  edge_d = 1'b0;
    else if (edge_evt && live) edge_d = 1'b1;
    else if (take_me)          edge_d = 1'b0;

    held_d = held_q;
    if (edge_mode || masked || drop || take_any) held_d = 1'b0;
    else if (active && live)                     held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      edge_q <= edge_d;
      held_q <= held_d;
    end
  end

  assign req = live & (edge_mode ? edge_q : (active | held_q));
endmodule

// File: rtl/pic_nmi.sv
`timescale 1ns/1ps
module pic_nmi #(
  parameter int BLANK_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic rise_sel,
  input  logic ctl_write,
  input  logic take_nmi,
  output logic pend
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1);

  logic             prev_q, prev_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_seen, blank;

  assign edge_seen = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);
  assign blank     = ctl_write | (cnt_q != '0);

  always_comb begin
    prev_d = pin_s;
    if (ctl_write)          cnt_d = CNT_W'(BLANK_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
    pend_d = pend_q;
    if (edge_seen && !blank) pend_d = 1'b1;
    else if (take_nmi)       pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/pic_sel.sv
`timescale 1ns/1ps
module pic_sel #(
  parameter int N_IRQ = 8,
  parameter int PRI_W = 4,
  localparam int LVL_W = PRI_W + 1,
  localparam int SRC_W = $clog2(N_IRQ + 1)
) (
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ*PRI_W-1:0] irq_lvl,
  input  logic                   nmi_pend,
  input  logic                   cpu_block,
  input  logic                   cpu_sleep,
  input  logic                   nmi_ovr,
  input  logic [LVL_W-1:0]       cpu_imask,
  output logic                   sel_valid,
  output logic [SRC_W-1:0]       sel_src,
  output logic [LVL_W-1:0]       sel_level
);
  localparam logic [SRC_W-1:0] NMI_SRC = SRC_W'(N_IRQ);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1) << PRI_W;

  logic [LVL_W-1:0] lv;

  always_comb begin
    sel_valid = 1'b0;
    sel_src   = '0;
    sel_level = '0;
    lv        = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      lv = {1'b0, irq_lvl[i*PRI_W +: PRI_W]};
      if (irq_req[i] && !cpu_block && (lv > cpu_imask) && (lv > sel_level)) begin
        sel_valid = 1'b1;
        sel_src   = SRC_W'(i);
        sel_level = lv;
      end
    end
    if (nmi_pend && (!cpu_block || cpu_sleep || nmi_ovr)) begin
      sel_valid = 1'b1;
      sel_src   = NMI_SRC;
      sel_level = NMI_LVL;
    end
  end
endmodule

// File: rtl/pic_core.sv
`timescale 1ns/1ps
module pic_core #(
  parameter int N_IRQ     = 8,
  parameter int PRI_W     = 4,
  parameter int BLANK_CYC = 6,
  localparam int LVL_W    = PRI_W + 1,
  localparam int SRC_W    = $clog2(N_IRQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             cpu_block,
  input  logic             cpu_sleep,
  input  logic [LVL_W-1:0] cpu_imask,
  output logic             req_valid,
  output logic [SRC_W-1:0] req_src,
  output logic [LVL_W-1:0] req_level,
  input  logic             ack,
  output logic             acc_valid,
  output logic [SRC_W-1:0] acc_src,
  output logic [LVL_W-1:0] acc_level,
  output logic [LVL_W-1:0] acc_imask
);
  import pic_pkg::*;

  localparam logic [SRC_W-1:0] NMI_SRC = SRC_W'(N_IRQ);

  logic [CTL_W-1:0]       ctl_q, ctl_d;
  logic [N_IRQ-1:0]       edge_q, edge_d;
  logic [N_IRQ-1:0]       polh_q, polh_d;
  logic [N_IRQ-1:0]       mask_q, mask_d;
  logic [N_IRQ*PRI_W-1:0] prio_q, prio_d;

  logic                   acc_valid_q, acc_valid_d;
  logic [SRC_W-1:0]       acc_src_q, acc_src_d;
  logic [LVL_W-1:0]       acc_level_q, acc_level_d;
  logic [LVL_W-1:0]       acc_imask_q, acc_imask_d;

  logic [N_IRQ:0]         pins_s;
  logic [N_IRQ-1:0]       irq_req;
  logic                   nmi_pend;
  logic                   accept, take_nmi, ctl_write;
  logic                   nmi_ovr, auto_mask;

  assign ctl_write = cfg_we && (cfg_addr == REG_CONTROL);
  assign nmi_ovr   = ctl_q[CTL_NMI_OVR];
  assign auto_mask = ctl_q[CTL_AUTO];

  // register file: next state
  always_comb begin
    ctl_d  = ctl_q;
    edge_d = edge_q;
    polh_d = polh_q;
    mask_d = mask_q;
    prio_d = prio_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        REG_CONTROL:  ctl_d  = cfg_wdata[CTL_W-1:0];
        REG_SENSE: begin
          edge_d = cfg_wdata[N_IRQ-1:0];
          polh_d = cfg_wdata[8 +: N_IRQ];
        end
        REG_MASK:     mask_d = cfg_wdata[N_IRQ-1:0];
        REG_PRIORITY: prio_d = cfg_wdata[N_IRQ*PRI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      edge_q <= '0;
      polh_q <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else if (cfg_we) begin
      ctl_q  <= ctl_d;
      edge_q <= edge_d;
      polh_q <= polh_d;
      mask_q <= mask_d;
      prio_q <= prio_d;
    end
  end

  pic_sync2 #(.W(N_IRQ + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nmi_pin, irq_pin}),
    .q     (pins_s)
  );

  assign accept   = ack && req_valid;
  assign take_nmi = accept && (req_src == NMI_SRC);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    pic_src #(.PRI_W(PRI_W)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pins_s[g]),
      .edge_mode (edge_q[g]),
      .pol_high  (polh_q[g]),
      .masked    (mask_q[g]),
      .lvl       (prio_q[g*PRI_W +: PRI_W]),
      .drop      (ctl_q[CTL_DROP]),
      .take_me   (accept && (req_src == SRC_W'(g))),
      .take_any  (accept),
      .req       (irq_req[g])
    );
  end

  pic_nmi #(.BLANK_CYC(BLANK_CYC)) u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s     (pins_s[N_IRQ]),
    .rise_sel  (ctl_q[CTL_NMI_RISE]),
    .ctl_write (ctl_write),
    .take_nmi  (take_nmi),
    .pend      (nmi_pend)
  );

  pic_sel #(.N_IRQ(N_IRQ), .PRI_W(PRI_W)) u_sel (
    .irq_req   (irq_req),
    .irq_lvl   (prio_q),
    .nmi_pend  (nmi_pend),
    .cpu_block (cpu_block),
    .cpu_sleep (cpu_sleep),
    .nmi_ovr   (nmi_ovr),
    .cpu_imask (cpu_imask),
    .sel_valid (req_valid),
    .sel_src   (req_src),
    .sel_level (req_level)
  );

  // acceptance report: next state
  always_comb begin
    acc_valid_d = accept;
    acc_src_d   = acc_src_q;
    acc_level_d = acc_level_q;
    acc_imask_d = acc_imask_q;
    if (accept) begin
      acc_src_d   = req_src;
      acc_level_d = req_level;
      acc_imask_d = (auto_mask && !take_nmi) ? req_level : cpu_imask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid_q <= 1'b0;
      acc_src_q   <= '0;
      acc_level_q <= '0;
      acc_imask_q <= '0;
    end else begin
      acc_valid_q <= acc_valid_d;
      acc_src_q   <= acc_src_d;
      acc_level_q <= acc_level_d;
      acc_imask_q <= acc_imask_d;
    end
  end

  assign acc_valid = acc_valid_q;
  assign acc_src   = acc_src_q;
  assign acc_level = acc_level_q;
  assign acc_imask = acc_imask_q;
endmodule

// File: rtl/pic_core_chk.sv
`timescale 1ns/1ps
module pic_core_chk #(
  parameter int N_IRQ = 8,
  parameter int PRI_W = 4,
  localparam int LVL_W = PRI_W + 1,
  localparam int SRC_W = $clog2(N_IRQ + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_block,
  input logic             cpu_sleep,
  input logic [LVL_W-1:0] cpu_imask,
  input logic             req_valid,
  input logic [SRC_W-1:0] req_src,
  input logic [LVL_W-1:0] req_level,
  input logic             ack,
  input logic             acc_valid,
  input logic [LVL_W-1:0] acc_imask,
  input logic             nmi_ovr,
  input logic             auto_mask,
  input logic [N_IRQ-1:0] mask_q
);
  localparam logic [SRC_W-1:0] NMI_SRC = SRC_W'(N_IRQ);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1) << PRI_W;

  logic [N_IRQ-1:0] src_onehot;
  assign src_onehot = N_IRQ'(1) << req_src;

  AST_NONZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_level != '0)); // R1

  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src == NMI_SRC) |-> (req_level == NMI_LVL)); // R2

  AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_block && !cpu_sleep && !nmi_ovr) |-> !req_valid); // R4

  AST_NMI_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid && req_src == NMI_SRC) |=> (acc_imask == $past(cpu_imask))); // R5

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src != NMI_SRC) |-> ((src_onehot & mask_q) == '0)); // R8

  AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid && auto_mask && req_src != NMI_SRC) |=> (acc_imask == $past(req_level))); // R9

  AST_ACC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(ack && req_valid)); // R9

  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src != NMI_SRC) |-> ((req_level > cpu_imask) && !cpu_block)); // R10
endmodule

bind pic_core pic_core_chk #(.N_IRQ(N_IRQ), .PRI_W(PRI_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_block (cpu_block),
  .cpu_sleep (cpu_sleep),
  .cpu_imask (cpu_imask),
  .req_valid (req_valid),
  .req_src   (req_src),
  .req_level (req_level),
  .ack       (ack),
  .acc_valid (acc_valid),
  .acc_imask (acc_imask),
  .nmi_ovr   (nmi_ovr),
  .auto_mask (auto_mask),
  .mask_q    (mask_q)
);

// File: tb/pic_core_tb.sv
`timescale 1ns/1ps
module pic_core_tb;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_pin;
  logic [7:0]  irq_pin;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        cpu_block, cpu_sleep;
  logic [4:0]  cpu_imask;
  logic        req_valid;
  logic [3:0]  req_src;
  logic [4:0]  req_level;
  logic        ack;
  logic        acc_valid;
  logic [3:0]  acc_src;
  logic [4:0]  acc_level;
  logic [4:0]  acc_imask;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_NS/2) clk = ~clk;

  pic_core u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cpu_block(cpu_block), .cpu_sleep(cpu_sleep), .cpu_imask(cpu_imask),
    .req_valid(req_valid), .req_src(req_src), .req_level(req_level),
    .ack(ack), .acc_valid(acc_valid), .acc_src(acc_src),
    .acc_level(acc_level), .acc_imask(acc_imask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic take();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  function automatic logic [31:0] prio_one(input int idx, input int lvl);
    return 32'(lvl & 15) << (4 * idx);
  endfunction

  // expected presented pin for level-mode, active-high, no NMI, unblocked
  function automatic logic [9:0] expect_pick(input logic [31:0] pr, input logic [7:0] mk,
                                              input logic [7:0] pins, input logic [4:0] im);
    logic [4:0] best = 0;
    logic [3:0] src = 0;
    logic       v = 0;
    for (int i = 0; i < 8; i++) begin
      logic [4:0] l = {1'b0, pr[4*i +: 4]};
      if (!mk[i] && pins[i] && l > im && l > best) begin
        best = l; src = 4'(i); v = 1'b1;
      end
    end
    return {v, src, best};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_pin = 0; irq_pin = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    cpu_block = 0; cpu_sleep = 0; cpu_imask = 0; ack = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("reset req_valid", 32'(req_valid), 0);
    chk("reset acc_valid", 32'(acc_valid), 0);

    // level mode, all active high, drop-on-withdraw
    wr(2'd0, 32'h4);
    wr(2'd1, 32'h0000_FF00);
    wr(2'd2, 32'h0);
    wr(2'd3, prio_one(3, 5));
    cyc(8);

    // R12 latency and R1 level
    irq_pin[3] = 1'b1;
    cyc(1);
    chk("R12 not yet after one edge", 32'(req_valid), 0);
    cyc(1);
    chk("R12 visible after two edges", 32'(req_valid), 1);
    chk("R1 src", 32'(req_src), 3);
    chk("R1 level", 32'(req_level), 5);
    wr(2'd3, 32'h0);
    cyc(1);
    chk("R1 level zero never presented", 32'(req_valid), 0);
    irq_pin[3] = 1'b0;

    // R10 mask level and block
    wr(2'd3, prio_one(2, 7));
    irq_pin[2] = 1'b1;
    cpu_imask = 7;
    cyc(3);
    chk("R10 level equal to mask hidden", 32'(req_valid), 0);
    cpu_imask = 6;
    cyc(1);
    chk("R10 level above mask shown", 32'(req_src), 2);
    chk("R10 valid", 32'(req_valid), 1);
    cpu_block = 1'b1;
    cyc(1);
    chk("R4 block hides pin", 32'(req_valid), 0);
    cpu_block = 1'b0; cpu_imask = 0;

    // R11 tie-break
    wr(2'd3, prio_one(1, 7) | prio_one(2, 7));
    irq_pin[1] = 1'b1;
    cyc(3);
    chk("R11 lower index wins tie", 32'(req_src), 1);
    wr(2'd3, prio_one(1, 7) | prio_one(2, 7) | prio_one(5, 9));
    irq_pin[5] = 1'b1;
    cyc(3);
    chk("R11 higher level wins", 32'(req_src), 5);

    // R9 auto mask
    wr(2'd0, 32'hC);
    cpu_imask = 3;
    cyc(1);
    take();
    chk("R9 acc_valid", 32'(acc_valid), 1);
    chk("R9 acc_src", 32'(acc_src), 5);
    chk("R9 acc_level", 32'(acc_level), 9);
    chk("R9 auto mask updates", 32'(acc_imask), 9);
    cyc(1);
    chk("R9 acc_valid one cycle", 32'(acc_valid), 0);
    wr(2'd0, 32'h4);
    take();
    chk("R9 no auto keeps mask", 32'(acc_imask), 3);
    irq_pin = 0; cpu_imask = 0;
    wr(2'd3, 32'h0);
    cyc(3);

    // R6 edge mode rising
    wr(2'd1, 32'h0000_FF10);
    wr(2'd3, prio_one(4, 6));
    cyc(2);
    irq_pin[4] = 1'b1;
    cyc(1);
    irq_pin[4] = 1'b0;
    cyc(4);
    chk("R6 edge latched after pulse", 32'(req_src), 4);
    chk("R6 edge valid", 32'(req_valid), 1);
    take();
    chk("R6 edge cleared by accept", 32'(req_valid), 0);
    // falling polarity
    wr(2'd1, 32'h0000_EF10);
    cyc(2);
    irq_pin[4] = 1'b1;
    cyc(4);
    chk("R6 rising ignored in falling mode", 32'(req_valid), 0);
    irq_pin[4] = 1'b0;
    cyc(4);
    chk("R6 falling edge latched", 32'(req_valid), 1);
    take();
    wr(2'd1, 32'h0000_FF00);
    wr(2'd3, prio_one(6, 4));

    // R7 hold on withdraw
    wr(2'd0, 32'h0);
    irq_pin[6] = 1'b1;
    cyc(3);
    irq_pin[6] = 1'b0;
    cyc(4);
    chk("R7 withdrawn level held", 32'(req_src), 6);
    chk("R7 held valid", 32'(req_valid), 1);
    take();
    chk("R7 held cleared by accept", 32'(req_valid), 0);
    wr(2'd0, 32'h4);
    irq_pin[6] = 1'b1;
    cyc(3);
    irq_pin[6] = 1'b0;
    cyc(4);
    chk("R7 drop mode withdraws", 32'(req_valid), 0);

    // R8 mask clears held level and latched edge
    wr(2'd0, 32'h0);
    irq_pin[6] = 1'b1;
    cyc(3);
    irq_pin[6] = 1'b0;
    cyc(3);
    wr(2'd2, 32'h40);
    cyc(1);
    chk("R8 masked hidden", 32'(req_valid), 0);
    wr(2'd2, 32'h0);
    cyc(1);
    chk("R8 held discarded by mask", 32'(req_valid), 0);
    wr(2'd1, 32'h0000_FF10);
    wr(2'd3, prio_one(4, 6));
    cyc(2);
    irq_pin[4] = 1'b1;
    cyc(4);
    wr(2'd2, 32'h10);
    cyc(1);
    wr(2'd2, 32'h0);
    cyc(1);
    chk("R8 edge discarded by mask", 32'(req_valid), 0);
    irq_pin[4] = 1'b0;
    wr(2'd1, 32'h0000_FF00);

    // R2 NMI rising beats pins, R5 keeps mask
    wr(2'd3, prio_one(0, 15));
    wr(2'd0, 32'hD);
    cyc(10);
    irq_pin[0] = 1'b1;
    cpu_imask = 2;
    nmi_pin = 1'b1;
    cyc(4);
    chk("R2 nmi src", 32'(req_src), 8);
    chk("R2 nmi level", 32'(req_level), 16);
    take();
    chk("R5 nmi accept keeps mask", 32'(acc_imask), 2);
    chk("R5 nmi acc_src", 32'(acc_src), 8);
    chk("R2 pin follows nmi", 32'(req_src), 0);
    wr(2'd0, 32'hC);
    cyc(10);
    nmi_pin = 1'b0;
    cyc(4);
    chk("R2 falling edge selected", 32'(req_src), 8);
    take();
    irq_pin[0] = 1'b0;
    cyc(3);

    // R3 blanking after control write
    wr(2'd0, 32'hD);
    nmi_pin = 1'b1;
    cyc(12);
    chk("R3 edge in blank window ignored", 32'(req_valid), 0);
    nmi_pin = 1'b0;
    cyc(10);
    nmi_pin = 1'b1;
    cyc(4);
    chk("R3 edge after window taken", 32'(req_src), 8);
    take();

    // R4 NMI under block
    cpu_block = 1'b1;
    nmi_pin = 1'b0;
    cyc(4);
    nmi_pin = 1'b1;
    cyc(4);
    chk("R4 nmi blocked", 32'(req_valid), 0);
    cpu_sleep = 1'b1;
    cyc(1);
    chk("R4 nmi taken in sleep", 32'(req_src), 8);
    cpu_sleep = 1'b0;
    wr(2'd0, 32'hF);
    chk("R4 nmi taken with override", 32'(req_valid), 1);
    take();
    cpu_block = 1'b0;
    nmi_pin = 1'b0;
    wr(2'd0, 32'h4);
    cyc(10);

    // random: R1 R10 R11
    void'($urandom(32'h1234_5678));
    for (int it = 0; it < 60; it++) begin
      logic [31:0] pr = $urandom;
      logic [7:0]  mk = 8'($urandom);
      logic [7:0]  pn = 8'($urandom);
      logic [4:0]  im = 5'($urandom_range(0, 16));
      logic [9:0]  e;
      wr(2'd3, pr);
      wr(2'd2, {24'h0, mk});
      irq_pin = pn; cpu_imask = im;
      cyc(3);
      e = expect_pick(pr, mk, pn, im);
      chk("R10 random valid", 32'(req_valid), 32'(e[9]));
      if (e[9]) begin
        chk("R11 random src", 32'(req_src), 32'(e[8:5]));
        chk("R1 random level", 32'(req_level), 32'(e[4:0]));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule